// File: doc/BRIEF.md
# Output Transmit Queue Scheduler

This block sits between the packet switching logic and the transmit side of one output interface. Each cycle it may accept one switched packet, identified only by a buffer handle. It places that handle either on a small transmit descriptor ring or at the tail of an output hold queue of configurable depth. The choice ensures that packets always leave in the order in which they arrived. A handle that finds the hold queue full is dropped. Its handle is returned at once on a drop port, and a drop counter advances.

The transmitter polls the head of the ring, sends that packet, and pulses a completion. On each completion the oldest descriptor is freed and its handle is returned on the release port so that the buffer can go back to its pool. If the hold queue is not empty, its oldest entry moves into the freed ring slot in the same cycle. A completion that arrives together with a new packet is resolved in two steps. First the held packet takes the freed slot. Then the new arrival is placed against what remains.

Top module: `txq_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `tx_count`, `hold_count` and `drop_count` are zero and `free_valid`, `drop_valid` and `tx_head_valid` are low.
- R2: An arrival that finds the hold queue empty and fewer than RING_DEPTH (4) descriptors pending goes straight onto the ring, and `tx_count` rises by one on the next cycle.
- R3: An arrival that finds the hold queue non-empty goes to the hold queue tail, even if a completion frees a ring slot in the same cycle.
- R4: An arrival that finds the ring full and the hold queue empty is placed in the hold queue. With no completion in that cycle, `hold_count` becomes 1 and `tx_count` stays at RING_DEPTH.
- R5: An arrival that finds HOLD_DEPTH handles held and no completion in the same cycle is dropped. On the next cycle `drop_valid` is high, `drop_handle` equals its handle, and `drop_count` has risen by one.
- R6: A completion (`tx_done` high with at least one descriptor pending) makes `free_valid` high on the next cycle, with `free_handle` equal to the oldest pending handle.
- R7: A completion while handles are held moves the oldest held handle onto the ring in the same cycle, so `tx_count` stays at RING_DEPTH. A simultaneous arrival is then placed in the hold queue, and it is accepted even when the queue was full.
- R8: `tx_done` while no descriptor is pending has no effect: no release, and no change to any count.
- R9: Handles leave through `tx_head` and `free_handle` in exactly their arrival order, leaving out the dropped ones.
- R10: `tx_count` equals the number of pending ring descriptors, never exceeds RING_DEPTH, and equals RING_DEPTH whenever `hold_count` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A switched packet is offered this cycle |
| in_handle | input | HW | Buffer handle of the offered packet |
| tx_done | input | 1 | Transmitter completion pulse for the head descriptor |
| tx_head_valid | output | 1 | At least one descriptor awaits transmission |
| tx_head | output | HW | Handle of the oldest pending descriptor |
| tx_count | output | clog2(RING_DEPTH+1) | Number of pending ring descriptors |
| hold_count | output | clog2(HOLD_DEPTH+1) | Number of handles in the hold queue |
| free_valid | output | 1 | A completed handle is being returned |
| free_handle | output | HW | Returned handle after completion |
| drop_valid | output | 1 | An arrival was dropped |
| drop_handle | output | HW | Handle of the dropped arrival |
| drop_count | output | DROP_W | Running count of dropped arrivals |

## Verification
The assertions assume that `tx_done` refers only to the current head descriptor and that at most one handle is offered per cycle. They also assume that each handle is held by the block at most once. The bench keeps within these limits by numbering its handles from a counter, so no handle repeats while it is inside the block. It raises `tx_done` freely, including on an empty ring, because the block must ignore that case. A behavioural queue model in the bench sets the expected ring, hold queue, release and drop outputs for every cycle. The stimulus runs directed fill, overflow and same-cycle collision sequences, and then random segments with different arrival and completion densities.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Placement decided for an offered handle in one cycle
  typedef enum logic [1:0] {
    RT_IDLE = 2'd0,
    RT_RING = 2'd1,
    RT_HOLD = 2'd2,
    RT_DROP = 2'd3
  } route_e;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head = mem[rd_ptr];

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    push |-> (32'(count) < DEPTH || pop));
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0);
  p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
    32'(count) <= DEPTH);
endmodule

// File: rtl/txq_admit.sv
module txq_admit
  import txq_pkg::*;
#(
  parameter int RING_DEPTH = 4,
  parameter int HOLD_DEPTH = 8,
  localparam int RCW = $clog2(RING_DEPTH + 1),
  localparam int HCW = $clog2(HOLD_DEPTH + 1)
) (
  input  logic           in_valid,
  input  logic           tx_done,
  input  logic [RCW-1:0] ring_cnt,
  input  logic [HCW-1:0] hold_cnt,
  output logic           done_ok,
  output logic           move,
  output route_e         route
);
  int  ring_after;
  logic hold_drained, ring_room, hold_room;

  always_comb begin
    done_ok      = tx_done && (ring_cnt != '0);
    // a freed slot is taken by the oldest held handle first
    move         = done_ok && (hold_cnt != '0);
    ring_after   = 32'(ring_cnt) - 32'(done_ok) + 32'(move);
    ring_room    = ring_after < RING_DEPTH;
    hold_drained = (hold_cnt == '0) || ((32'(hold_cnt) == 1) && move);
    hold_room    = (32'(hold_cnt) < HOLD_DEPTH) || move;
    if (!in_valid)                     route = RT_IDLE;
    else if (hold_drained && ring_room) route = RT_RING;
    else if (hold_room)                route = RT_HOLD;
    else                               route = RT_DROP;
  end
endmodule

// File: rtl/txq_sched.sv
module txq_sched
  import txq_pkg::*;
#(
  parameter int HW         = 8,
  parameter int RING_DEPTH = 4,
  parameter int HOLD_DEPTH = 8,
  parameter int DROP_W     = 16,
  localparam int RCW = $clog2(RING_DEPTH + 1),
  localparam int HCW = $clog2(HOLD_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [HW-1:0]     in_handle,
  input  logic              tx_done,
  output logic              tx_head_valid,
  output logic [HW-1:0]     tx_head,
  output logic [RCW-1:0]    tx_count,
  output logic [HCW-1:0]    hold_count,
  output logic              free_valid,
  output logic [HW-1:0]     free_handle,
  output logic              drop_valid,
  output logic [HW-1:0]     drop_handle,
  output logic [DROP_W-1:0] drop_count
);
  logic          done_ok, move;
  route_e        route;
  logic [HW-1:0] hold_head, ring_head, ring_in;
  logic          ring_push, hold_push;

  txq_admit #(.RING_DEPTH(RING_DEPTH), .HOLD_DEPTH(HOLD_DEPTH)) u_admit (
    .in_valid (in_valid),
    .tx_done  (tx_done),
    .ring_cnt (tx_count),
    .hold_cnt (hold_count),
    .done_ok  (done_ok),
    .move     (move),
    .route    (route)
  );

  assign ring_push = move || (route == RT_RING);
  assign ring_in   = move ? hold_head : in_handle;
  assign hold_push = (route == RT_HOLD);

  txq_fifo #(.W(HW), .DEPTH(RING_DEPTH)) u_ring (
    .clk (clk), .rst (rst),
    .push (ring_push), .push_data (ring_in),
    .pop (done_ok), .head (ring_head), .count (tx_count)
  );

  txq_fifo #(.W(HW), .DEPTH(HOLD_DEPTH)) u_hold (
    .clk (clk), .rst (rst),
    .push (hold_push), .push_data (in_handle),
    .pop (move), .head (hold_head), .count (hold_count)
  );

  assign tx_head_valid = (tx_count != '0);
  assign tx_head       = ring_head;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_valid  <= 1'b0;
      free_handle <= '0;
      drop_valid  <= 1'b0;
      drop_handle <= '0;
      drop_count  <= '0;
    end else begin
      free_valid <= done_ok;
      if (done_ok) free_handle <= ring_head;
      drop_valid <= (route == RT_DROP);
      if (route == RT_DROP) begin
        drop_handle <= in_handle;
        drop_count  <= drop_count + 1'b1;
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (tx_count == '0 && hold_count == '0 && !free_valid && !drop_valid && drop_count == '0));
  p_hold_means_full_r10: assert property (@(posedge clk) disable iff (rst)
    hold_count != '0 |-> 32'(tx_count) == RING_DEPTH);
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_done && tx_count != '0) |=> free_valid);
  p_idle_done_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_done && tx_count == '0) |=> !free_valid);
  p_refill_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_done && hold_count != '0) |=> 32'(tx_count) == RING_DEPTH);
  p_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && 32'(hold_count) == HOLD_DEPTH && !tx_done) |=> (drop_valid && drop_count == $past(drop_count) + 1'b1));
  p_queue_tail_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !tx_done && hold_count != '0 && 32'(hold_count) < HOLD_DEPTH) |=> hold_count == $past(hold_count) + 1'b1);
  p_direct_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !tx_done && hold_count == '0 && 32'(tx_count) < RING_DEPTH) |=> tx_count == $past(tx_count) + 1'b1);
endmodule

// File: tb/txq_sched_tb.sv
module txq_sched_tb;
  localparam int HW = 8;
  localparam int RD = 4;
  localparam int HD = 8;
  localparam int DW = 16;
  localparam int RCW = $clog2(RD + 1);
  localparam int HCW = $clog2(HD + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [HW-1:0] in_handle = '0;
  logic tx_done = 1'b0;
  logic tx_head_valid;
  logic [HW-1:0] tx_head, free_handle, drop_handle;
  logic [RCW-1:0] tx_count;
  logic [HCW-1:0] hold_count;
  logic free_valid, drop_valid;
  logic [DW-1:0] drop_count;

  always #2 clk = ~clk;

  txq_sched #(.HW(HW), .RING_DEPTH(RD), .HOLD_DEPTH(HD), .DROP_W(DW)) u_dut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_handle (in_handle),
    .tx_done (tx_done), .tx_head_valid (tx_head_valid), .tx_head (tx_head),
    .tx_count (tx_count), .hold_count (hold_count), .free_valid (free_valid),
    .free_handle (free_handle), .drop_valid (drop_valid),
    .drop_handle (drop_handle), .drop_count (drop_count)
  );

  // reference model state
  int ring_q[$];
  int hold_q[$];
  int m_drops = 0;
  bit m_free = 0, m_drop = 0;
  int m_free_h = 0, m_drop_h = 0;
  int next_h = 0;

  int n_checks = 0;
  int n_fail = 0;
  bit done_flag = 0;

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R10 tx_count", int'(tx_count) == ring_q.size(), int'(tx_count), ring_q.size());
    check("R3 hold_count", int'(hold_count) == hold_q.size(), int'(hold_count), hold_q.size());
    check("R10 head valid", tx_head_valid == (ring_q.size() > 0), int'(tx_head_valid), int'(ring_q.size() > 0));
    if (ring_q.size() > 0)
      check("R9 head order", int'(tx_head) == ring_q[0], int'(tx_head), ring_q[0]);
    check("R6 free_valid", free_valid == m_free, int'(free_valid), int'(m_free));
    if (m_free)
      check("R6 free_handle", int'(free_handle) == m_free_h, int'(free_handle), m_free_h);
    check("R5 drop_valid", drop_valid == m_drop, int'(drop_valid), int'(m_drop));
    if (m_drop)
      check("R5 drop_handle", int'(drop_handle) == m_drop_h, int'(drop_handle), m_drop_h);
    check("R5 drop_count", int'(drop_count) == (m_drops % (1 << DW)), int'(drop_count), m_drops);
  endtask

  task automatic model_step(input bit v, input int h, input bit d);
    m_free = 0;
    m_drop = 0;
    if (d && ring_q.size() > 0) begin
      m_free = 1;
      m_free_h = ring_q.pop_front();
      if (hold_q.size() > 0) ring_q.push_back(hold_q.pop_front());
    end
    if (v) begin
      if (hold_q.size() == 0 && ring_q.size() < RD) ring_q.push_back(h);
      else if (hold_q.size() < HD) hold_q.push_back(h);
      else begin
        m_drop = 1;
        m_drop_h = h;
        m_drops++;
      end
    end
  endtask

  task automatic step(input bit v, input bit d);
    int h;
    @(negedge clk);
    compare_all();
    h = next_h % (1 << HW);
    in_valid  = v;
    in_handle = HW'(h);
    tx_done   = d;
    if (v) next_h++;
    model_step(v, h, d);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 tx_count", tx_count == '0, int'(tx_count), 0);
    check("R1 hold_count", hold_count == '0, int'(hold_count), 0);
    check("R1 free_valid", !free_valid, int'(free_valid), 0);
    check("R1 drop_valid", !drop_valid, int'(drop_valid), 0);
    check("R1 head_valid", !tx_head_valid, int'(tx_head_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", tx_count == '0 && drop_count == '0, int'(tx_count), 0);

    // R2: direct to ring
    repeat (RD) step(1, 0);
    step(0, 0);
    check("R2 ring filled", int'(tx_count) == RD, int'(tx_count), RD);
    check("R2 head is first", int'(tx_head) == 0, int'(tx_head), 0);
    // R4: ring full -> hold
    step(1, 0);
    step(0, 0);
    check("R4 into hold", int'(hold_count) == 1 && int'(tx_count) == RD, int'(hold_count), 1);
    // R3: hold nonempty -> tail
    repeat (HD - 1) step(1, 0);
    step(0, 0);
    check("R3 hold full", int'(hold_count) == HD, int'(hold_count), HD);
    // R5: drop when full
    step(1, 0);
    step(0, 0);
    check("R5 dropped", drop_valid && int'(drop_handle) == RD + HD, int'(drop_handle), RD + HD);
    check("R5 drop count", int'(drop_count) == 1, int'(drop_count), 1);
    // R7: completion and arrival together on a full hold queue
    step(1, 1);
    step(0, 0);
    check("R7 freed head", free_valid && int'(free_handle) == 0, int'(free_handle), 0);
    check("R7 ring refilled", int'(tx_count) == RD, int'(tx_count), RD);
    check("R7 arrival accepted", int'(hold_count) == HD && int'(drop_count) == 1, int'(hold_count), HD);
    check("R9 next head", int'(tx_head) == 1, int'(tx_head), 1);
    // drain, then R8: completion on empty ring
    repeat (RD + HD + 4) step(0, 1);
    step(0, 0);
    check("R8 idle done ignored", !free_valid && tx_count == '0, int'(free_valid), 0);

    // random segments with different densities
    for (int seg = 0; seg < 6; seg++) begin
      int pin, pdn;
      pin = 20 + seg * 15;
      pdn = 95 - seg * 15;
      for (int c = 0; c < 500; c++)
        step($urandom_range(99) < pin, $urandom_range(99) < pdn);
    end
    step(0, 0);
    step(0, 0);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule